// File: doc/BRIEF.md
# Twelve-Source Hit Word Merger

This block collects timing words from twelve small hit buffers, each shared by a pair of detector channels, and funnels them into one output buffer that a downstream serial transmitter drains. Each source buffer shows its oldest word on its data lines while its empty flag is low, and the merger pops it with a one-cycle read strobe. The merger pops at most one word per cycle. It picks the source by a rotating scan that starts just after the last source it served and passes over empty sources.

Each 18-bit input word carries a pair-member flag in bit 17, a 4-bit circulation count in bits 16..13 and a 13-bit bunch count in bits 12..0. On the way out, the merger replaces the pair flag with a 5-bit channel number. That number is the source index times two plus the pair flag, which gives 24 distinct channels. The merger also puts two live status bits in front of the word. The 24-bit result goes into an output buffer of 512 words by default. That buffer is first-word-fall-through: its head word is visible while `out_empty` is low, and `out_rd` pops it.

A three-state controller sets the pace. ST_IDLE means no source has data. ST_MOVE means a word was forwarded. ST_WAIT means the output buffer was full. The transitions are:
- From ST_IDLE or ST_MOVE, go to ST_WAIT when the output buffer is full.
- From ST_IDLE or ST_MOVE, go to ST_MOVE when some source holds data and there is space.
- From ST_IDLE or ST_MOVE, otherwise go to ST_IDLE.
- From ST_WAIT, return to ST_IDLE once space exists.

No source is read while the controller is in ST_WAIT.

Top module: `hit_merger`

## Requirements
- R1: After reset `out_empty` is 1, `out_full` is 0 and `src_rd` is all zero.
- R2: An output word is {status[1:0], chan[4:0], in[16:0]}, where chan = 2*source_index + in[17]. Bits 16..0 of the input are copied unchanged into bits 16..0 of the output.
- R3: Sources are served in rotating order. The scan starts at the index after the last served source, wrapping from 11 to 0. After reset it starts at index 0. Empty sources are skipped.
- R4: At most one `src_rd` bit is high in any cycle, and never for a source whose empty flag is high.
- R5: Output bit 23 equals the OR of all `src_ovf` inputs in the cycle the word is written.
- R6: Output bit 22 is 1 when the output buffer already holds at least AFULL_LEVEL words in the cycle the word is written, and 0 otherwise.
- R7: While `out_full` is high, no source is read. Forwarding resumes after space frees, and no word is lost or duplicated.
- R8: `out_data` shows the oldest stored word while `out_empty` is 0, and `out_rd` removes it. An `out_rd` pulse while `out_empty` is 1 has no effect.
- R9: `out_full` is 1 exactly when the output buffer holds OUT_DEPTH words.
- R10: A word sitting at the head of a source when the block is in ST_IDLE or ST_MOVE, and there is space, is written at the next rising edge. It is visible on `out_data` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_empty | input | 12 | Empty flag of each source buffer |
| src_word | input | 216 | Head words of the sources; source i occupies bits 18*i+17..18*i |
| src_ovf | input | 12 | Overflow indication of each source buffer |
| src_rd | output | 12 | One-cycle pop strobe per source |
| out_rd | input | 1 | Pop strobe from the serializer |
| out_data | output | 24 | Head word of the output buffer |
| out_empty | output | 1 | Output buffer is empty |
| out_full | output | 1 | Output buffer is full |

## Verification
A word loaded at a source before a rising edge is due on `out_data` at the next falling edge. The single-word checks sample exactly there, one edge after the load. Multi-word scenarios wait a fixed number of cycles that covers one word per cycle. They then check the order and contents word by word with `out_rd` pulses, sampling one falling edge after each pop. The full-buffer scenario counts source reads while `out_full` is high at every falling edge, and it checks the bit-22 boundary by the write position of each word.

// File: rtl/hm_pkg.sv
package hm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_WAIT = 2'd2
    } hm_state_t;
endpackage

// File: rtl/hm_rr_pick.sv
module hm_rr_pick #(
    parameter int N     = 12,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int off = 1; off <= N; off++) begin
            int cand;
            cand = int'(last) + off;
            if (cand >= N) cand = cand - N;
            if (!any && req[cand]) begin
                any = 1'b1;
                idx = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/hm_out_fifo.sv
module hm_out_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 512,
    parameter int AFULL = 384
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         afull
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign afull   = (cnt >= CW'(AFULL));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);                                            // R7
    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> empty);                       // R8
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);                                  // R9
endmodule

// File: rtl/hit_merger.sv
module hit_merger
    import hm_pkg::*;
#(
    parameter int N_SRC       = 12,
    parameter int IN_W        = 18,
    parameter int OUT_DEPTH   = 512,
    parameter int AFULL_LEVEL = 384
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      src_empty,
    input  logic [N_SRC*IN_W-1:0] src_word,
    input  logic [N_SRC-1:0]      src_ovf,
    output logic [N_SRC-1:0]      src_rd,
    input  logic                  out_rd,
    output logic [23:0]           out_data,
    output logic                  out_empty,
    output logic                  out_full
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int ID_W  = IDX_W + 1;
    localparam int OUT_W = 2 + ID_W + IN_W - 1;

    logic [IN_W-1:0]  words [N_SRC];
    logic [IDX_W-1:0] last_q, pick;
    logic             any_req, fire, ofull, oafull;
    logic [OUT_W-1:0] wr_word;
    logic [OUT_W-1:0] rd_word;
    hm_state_t        state_q, state_d;

    for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
        assign words[g] = src_word[g*IN_W +: IN_W];
    end

    hm_rr_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
        .req  (~src_empty),
        .last (last_q),
        .any  (any_req),
        .idx  (pick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_MOVE: begin
                if (ofull)        state_d = ST_WAIT;
                else if (any_req) state_d = ST_MOVE;
                else              state_d = ST_IDLE;
            end
            ST_WAIT: if (!ofull) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            last_q  <= IDX_W'(N_SRC - 1);
        end else begin
            state_q <= state_d;
            if (fire) last_q <= pick;
        end
    end

    always_comb begin
        fire    = (state_q != ST_WAIT) && any_req && !ofull;
        src_rd  = '0;
        if (fire) src_rd[pick] = 1'b1;
        wr_word = {|src_ovf, oafull, pick, words[pick][IN_W-1],
                   words[pick][IN_W-2:0]};
    end

    hm_out_fifo #(.W(OUT_W), .DEPTH(OUT_DEPTH), .AFULL(AFULL_LEVEL)) u_ofifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fire),
        .wr_data (wr_word),
        .rd_en   (out_rd),
        .rd_data (rd_word),
        .empty   (out_empty),
        .full    (ofull),
        .afull   (oafull)
    );

    assign out_full = ofull;
    assign out_data = 24'(rd_word);

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_rd));                                           // R4
    AST_READ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd & src_empty) == '0);                                 // R4
    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> (src_rd == '0));                                // R7
    AST_WAIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (src_rd == '0));                    // R7
    AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_rd && out_empty) |=> !out_empty);                      // R10
endmodule

// File: tb/hit_merger_bench.sv
module hit_merger_bench;
    localparam int N   = 12;
    localparam int IW  = 18;
    localparam int DEP = 16;
    localparam int AF  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_empty;
    logic [N*IW-1:0] src_word;
    logic [N-1:0]  src_ovf = '0;
    logic [N-1:0]  src_rd;
    logic          out_rd = 1'b0;
    logic [23:0]   out_data;
    logic          out_empty, out_full;

    int checks = 0;
    int fails  = 0;
    int full_reads = 0;

    logic [IW-1:0] q [N][8];
    int            head [N];
    int            tail [N];

    always #10 clk = ~clk;

    hit_merger #(.N_SRC(N), .IN_W(IW), .OUT_DEPTH(DEP), .AFULL_LEVEL(AF)) u_hit_merger (
        .clk(clk), .rst_n(rst_n), .src_empty(src_empty), .src_word(src_word),
        .src_ovf(src_ovf), .src_rd(src_rd), .out_rd(out_rd), .out_data(out_data),
        .out_empty(out_empty), .out_full(out_full)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            src_empty[i] = (head[i] == tail[i]);
            src_word[i*IW +: IW] = q[i][head[i] % 8];
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) head[i] <= 0;
            else if (src_rd[i]) head[i] <= head[i] + 1;
        end
    end

    always @(negedge clk) if (rst_n && out_full && (src_rd != '0)) full_reads++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(int s, logic [IW-1:0] w);
        q[s][tail[s] % 8] = w;
        tail[s] = tail[s] + 1;
    endtask

    function automatic logic [IW-1:0] mkw(int s, int j);
        return {1'(j), 4'(j + 1), 13'(s * 16 + j)};
    endfunction

    function automatic logic [23:0] expw(logic [1:0] st, int s, logic [IW-1:0] w);
        return {st, 4'(s), w};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) tail[i] = 0;
        src_ovf = '0;
        out_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pop();
        out_rd = 1'b1;
        @(negedge clk);
        out_rd = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 out_empty", 32'(out_empty), 1);
        chk("R1 out_full", 32'(out_full), 0);
        chk("R1 src_rd", 32'(src_rd), 0);
    endtask

    task automatic t_single();
        logic [IW-1:0] w;
        do_reset();
        w = {1'b1, 4'd3, 13'h123};
        push(5, w);
        @(negedge clk);
        chk("R10 visible after one edge", 32'(out_empty), 0);
        chk("R2 word and channel 11", 32'(out_data), 32'(expw(2'b00, 5, w)));
        chk("R2 channel field", 32'(out_data[21:17]), 11);
        pop();
        chk("R8 empty after pop", 32'(out_empty), 1);
    endtask

    task automatic t_rotate();
        int order [6] = '{0, 3, 7, 0, 3, 7};
        int seq [N];
        do_reset();
        for (int j = 0; j < 2; j++) begin
            push(7, mkw(7, j)); push(0, mkw(0, j)); push(3, mkw(3, j));
        end
        repeat (8) @(negedge clk);
        for (int i = 0; i < N; i++) seq[i] = 0;
        for (int k = 0; k < 6; k++) begin
            int s = order[k];
            chk("R3 rotating order", 32'(out_data), 32'(expw(2'b00, s, mkw(s, seq[s]))));
            seq[s]++;
            pop();
        end
        chk("R3 all consumed", 32'(out_empty), 1);
    endtask

    task automatic t_ovf();
        do_reset();
        src_ovf = 12'h040;
        push(2, mkw(2, 0));
        @(negedge clk);
        src_ovf = '0;
        push(9, mkw(9, 1));
        @(negedge clk);
        chk("R5 overflow bit set", 32'(out_data[23]), 1);
        pop();
        chk("R5 overflow bit clear", 32'(out_data[23]), 0);
        chk("R2 second word", 32'(out_data), 32'(expw(2'b00, 9, mkw(9, 1))));
        pop();
    endtask

    task automatic t_empty_read();
        do_reset();
        pop();
        chk("R8 empty read ignored", 32'(out_empty), 1);
        push(4, mkw(4, 0));
        @(negedge clk);
        chk("R8 word after empty read", 32'(out_data), 32'(expw(2'b00, 4, mkw(4, 0))));
        pop();
        chk("R8 single pop empties", 32'(out_empty), 1);
    endtask

    task automatic t_full();
        int k;
        do_reset();
        full_reads = 0;
        for (int j = 0; j < 2; j++)
            for (int s = 0; s < N; s++) push(s, mkw(s, j));
        repeat (24) @(negedge clk);
        chk("R9 full after depth writes", 32'(out_full), 1);
        begin
            int left = 0;
            for (int s = 0; s < N; s++) left += tail[s] - head[s];
            chk("R7 sources held back", 32'(left), 8);
        end
        k = 0;
        for (int j = 0; j < 2; j++) begin
            for (int s = 0; s < N; s++) begin
                if (k < DEP)
                    chk("R6 almost-full bit", 32'(out_data[22]), (k >= AF) ? 1 : 0);
                chk("R7 no loss in order", 32'(out_data[21:0]), 32'(expw(2'b00, s, mkw(s, j))));
                pop();
                @(negedge clk);
                k++;
            end
        end
        chk("R7 drained", 32'(out_empty), 1);
        chk("R7 no read while full", 32'(full_reads), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            tail[i] = 0;
            for (int d = 0; d < 8; d++) q[i][d] = '0;
        end
        t_reset();
        t_single();
        t_rotate();
        t_ovf();
        t_empty_read();
        t_full();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule